// File: doc/BRIEF.md
# Pipelined Cartesian-to-Polar Vectoring Converter

This block turns a stream of signed fixed-point coordinate pairs into polar form. Each sample carries an x value, a y value and a starting angle. The block returns the length of the vector, still multiplied by the constant rotation gain, and the starting angle plus the vector's own direction. The iterative shift-and-add method is fully unrolled. Every micro-rotation has its own register stage, so a new sample can enter on every clock and a finished result leaves on every clock once the pipe has filled.

Plain micro-rotations only converge for vectors whose direction lies within a quarter turn of the positive x axis. A leading stage therefore turns any vector that has a negative x by a quarter turn into the right half-plane and charges that quarter turn to the angle. Each following stage uses a fixed wired shift and a constant arctangent. The direction of each stage is picked so that the residual y shrinks toward zero. A valid bit travels beside the data. Removing the gain is left to the consumer.

Top module: `cordic_vec_pipe`

## Requirements
- R1: While rst_n is low, out_valid is 0 whatever in_valid does. After release, out_valid stays 0 until a sample accepted after release has crossed the pipe.
- R2: A sample accepted at rising edge k (in_valid high) is presented with out_valid high right after edge k+STAGES. Its result occupies STAGES+1 register levels in total.
- R3: One result leaves per clock. The output valid pattern repeats the input valid pattern exactly, gaps included, and no result appears that was not fed in.
- R4: out_mag equals G*sqrt(x^2+y^2) within a small truncation tolerance, where G is the product over i=0..STAGES-1 of sqrt(1+2^-2i), about 1.647 for 16 stages.
- R5: Angles are two's complement ANG_W-bit values with +pi mapped to 2^(ANG_W-1). out_phase equals in_phase + atan2(y, x), taken modulo 2^ANG_W, within a small tolerance.
- R6: Vectors with negative x (left half-plane) converge with the same accuracy as right-half vectors. A quarter-turn pre-rotation is applied: clockwise when y >= 0 and counter-clockwise when y < 0.
- R7: When in_phase plus the vector direction passes +pi or -pi, out_phase wraps modulo 2^ANG_W. It does not saturate.
- R8: A zero vector (x = 0, y = 0) gives out_mag exactly 0.
- R9: Full-scale inputs, including x = y = -2^(DATA_W-1), do not overflow. The two guard bits in the x/y datapath absorb the gain growth, and x never decreases from one stage to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Sample on in_x/in_y/in_phase is valid this cycle |
| in_x | input | DATA_W | Signed x coordinate |
| in_y | input | DATA_W | Signed y coordinate |
| in_phase | input | ANG_W | Starting angle, two's complement, pi = 2^(ANG_W-1) |
| out_valid | output | 1 | Result on out_mag/out_phase is valid |
| out_mag | output | DATA_W+2 | Gain-scaled magnitude, never negative |
| out_phase | output | ANG_W | in_phase plus vector direction, wrapping |

## Verification
The quarter-turn pre-rotation and the wrap of the angle accumulator can both act on one sample. A left-half-plane vector fed with a starting angle close to +pi receives the extra quarter turn in the leading stage and then passes the +pi boundary. The bench feeds such a vector back-to-back with ordinary samples. It compares the phase with the real-valued expectation modulo 2^ANG_W, so a saturating accumulator or a wrong pre-rotation direction both appear as an error of about half a turn. Full circular sweeps with shifting start angles reach the same coincidence at many other points.

// File: rtl/cordic_vec_pkg.sv
package cordic_vec_pkg;

  localparam int GUARD_BITS = 2;

  // atan(2^-i) with a half turn scaled to 2^31
  function automatic logic [31:0] atan_q31(input int idx);
    logic [31:0] r;
    case (idx)
      0:  r = 32'd536870912;
      1:  r = 32'd316933406;
      2:  r = 32'd167458907;
      3:  r = 32'd85004756;
      4:  r = 32'd42667331;
      5:  r = 32'd21354465;
      6:  r = 32'd10679838;
      7:  r = 32'd5340245;
      8:  r = 32'd2670163;
      9:  r = 32'd1335087;
      10: r = 32'd667544;
      11: r = 32'd333772;
      12: r = 32'd166886;
      13: r = 32'd83443;
      14: r = 32'd41722;
      15: r = 32'd20861;
      16: r = 32'd10430;
      17: r = 32'd5215;
      18: r = 32'd2608;
      19: r = 32'd1304;
      20: r = 32'd652;
      21: r = 32'd326;
      22: r = 32'd163;
      23: r = 32'd81;
      24: r = 32'd41;
      25: r = 32'd20;
      26: r = 32'd10;
      27: r = 32'd5;
      28: r = 32'd3;
      29: r = 32'd1;
      30: r = 32'd1;
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  // rounded rescale to an aw-bit angle word (aw in 2..31)
  function automatic logic [31:0] atan_scaled(input int idx, input int aw);
    logic [32:0] sum;
    sum = {1'b0, atan_q31(idx)} + (33'd1 << (31 - aw));
    return 32'(sum >> (32 - aw));
  endfunction

endpackage

// File: rtl/cordic_vec_prerot.sv
module cordic_vec_prerot #(
  parameter int DATA_W = 16,
  parameter int IW     = 18,
  parameter int AW     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_in,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [DATA_W-1:0] y_in,
  input  logic        [AW-1:0] z_in,
  output logic                 v_q,
  output logic signed [IW-1:0] x_q,
  output logic signed [IW-1:0] y_q,
  output logic        [AW-1:0] z_q
);

  localparam logic [AW-1:0] QUARTER = AW'(1) << (AW - 2);

  logic signed [IW-1:0] x_ext, y_ext, x_n, y_n;
  logic        [AW-1:0] z_n;

  always_comb begin
    x_ext = IW'(x_in);
    y_ext = IW'(y_in);
    x_n   = x_ext;
    y_n   = y_ext;
    z_n   = z_in;
    if (x_ext[IW-1]) begin
      if (!y_ext[IW-1]) begin
        // quarter turn clockwise
        x_n = y_ext;
        y_n = -x_ext;
        z_n = z_in + QUARTER;
      end else begin
        // quarter turn counter-clockwise
        x_n = -y_ext;
        y_n = x_ext;
        z_n = z_in - QUARTER;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (v_in) begin
      x_q <= x_n;
      y_q <= y_n;
      z_q <= z_n;
    end
  end

  assert_right_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    v_in |=> (x_q >= 0));

  assert_valid_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    v_in |=> v_q);

endmodule

// File: rtl/cordic_vec_stage.sv
module cordic_vec_stage #(
  parameter int            IW    = 18,
  parameter int            AW    = 16,
  parameter int            SHIFT = 0,
  parameter logic [AW-1:0] ATAN  = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_in,
  input  logic signed [IW-1:0] x_in,
  input  logic signed [IW-1:0] y_in,
  input  logic        [AW-1:0] z_in,
  output logic                 v_q,
  output logic signed [IW-1:0] x_q,
  output logic signed [IW-1:0] y_q,
  output logic        [AW-1:0] z_q
);

  logic                 cw;
  logic signed [IW-1:0] x_sh, y_sh, x_n, y_n;
  logic        [AW-1:0] z_n;

  always_comb begin
    cw   = ~y_in[IW-1];
    x_sh = x_in >>> SHIFT;
    y_sh = y_in >>> SHIFT;
    if (cw) begin
      x_n = x_in + y_sh;
      y_n = y_in - x_sh;
      z_n = z_in + ATAN;
    end else begin
      x_n = x_in - y_sh;
      y_n = y_in + x_sh;
      z_n = z_in - ATAN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (v_in) begin
      x_q <= x_n;
      y_q <= y_n;
      z_q <= z_n;
    end
  end

  assert_valid_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !v_in |=> !v_q);

  assert_x_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && x_in >= 0) |=> (x_q >= $past(x_in)));

endmodule

// File: rtl/cordic_vec_pipe.sv
module cordic_vec_pipe #(
  parameter int DATA_W = 16,
  parameter int ANG_W  = 16,
  parameter int STAGES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [DATA_W-1:0] in_x,
  input  logic signed [DATA_W-1:0] in_y,
  input  logic [ANG_W-1:0]        in_phase,
  output logic                    out_valid,
  output logic [DATA_W+1:0]       out_mag,
  output logic [ANG_W-1:0]        out_phase
);

  localparam int IW = DATA_W + cordic_vec_pkg::GUARD_BITS;

  logic                 v_s [STAGES+1];
  logic signed [IW-1:0] x_s [STAGES+1];
  logic signed [IW-1:0] y_s [STAGES+1];
  logic    [ANG_W-1:0]  z_s [STAGES+1];

  cordic_vec_prerot #(.DATA_W(DATA_W), .IW(IW), .AW(ANG_W)) u_prerot (
    .clk   (clk),
    .rst_n (rst_n),
    .v_in  (in_valid),
    .x_in  (in_x),
    .y_in  (in_y),
    .z_in  (in_phase),
    .v_q   (v_s[0]),
    .x_q   (x_s[0]),
    .y_q   (y_s[0]),
    .z_q   (z_s[0])
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    cordic_vec_stage #(
      .IW    (IW),
      .AW    (ANG_W),
      .SHIFT (g),
      .ATAN  (ANG_W'(cordic_vec_pkg::atan_scaled(g, ANG_W)))
    ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .v_in  (v_s[g]),
      .x_in  (x_s[g]),
      .y_in  (y_s[g]),
      .z_in  (z_s[g]),
      .v_q   (v_s[g+1]),
      .x_q   (x_s[g+1]),
      .y_q   (y_s[g+1]),
      .z_q   (z_s[g+1])
    );
  end

  assign out_valid = v_s[STAGES];
  assign out_mag   = x_s[STAGES];
  assign out_phase = z_s[STAGES];

  assert_mag_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_mag[DATA_W+1]);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> !out_valid);

endmodule

// File: tb/cordic_vec_pipe_tb.sv
module cordic_vec_pipe_tb;

  localparam int DW  = 16;
  localparam int AW  = 16;
  localparam int NST = 16;
  localparam real PI = 3.14159265358979;
  localparam real MAG_TOL = 40.0;
  localparam real PH_TOL  = 24.0;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_valid;
  logic signed [DW-1:0] in_x, in_y;
  logic [AW-1:0]        in_phase;
  logic                 out_valid;
  logic [DW+1:0]        out_mag;
  logic [AW-1:0]        out_phase;

  cordic_vec_pipe #(.DATA_W(DW), .ANG_W(AW), .STAGES(NST)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_phase(in_phase), .out_valid(out_valid), .out_mag(out_mag),
    .out_phase(out_phase)
  );

  always #10 clk = ~clk;

  typedef struct {
    real mag;
    real ph;
    int  due;
    int  kind;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   mon_on = 1'b0;
  real  gain;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0f expected %0f", req, what, act, expv);
    end
  endtask

  function automatic int rnd(input real v);
    int r;
    if (v >= 0.0) r = $rtoi(v + 0.5);
    else          r = -$rtoi(-v + 0.5);
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic string tag_of(input int kind, input bit is_phase);
    case (kind)
      1: return "R6";
      2: return is_phase ? "R7" : "R4";
      3: return "R8";
      4: return is_phase ? "R5" : "R9";
      default: return is_phase ? "R5" : "R4";
    endcase
  endfunction

  // drive one sample; kind: 0 plain, 1 left half, 2 wrap, 3 zero, 4 full scale
  task automatic send(input int x, input int y, input int ph, input int kind);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_x     = DW'(x);
    in_y     = DW'(y);
    in_phase = AW'(ph);
    e.mag  = gain * $sqrt(real'(x) * real'(x) + real'(y) * real'(y));
    e.ph   = real'(ph) + $atan2(real'(y), real'(x)) * 32768.0 / PI;
    e.due  = cyc + 1 + NST;
    e.kind = (kind == 0 && x < 0) ? 1 : kind;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        real d;
        e = q.pop_front();
        chk(out_valid == 1'b1, "R2", "out_valid at expected latency",
            real'(out_valid), 1.0);
        if (out_valid) begin
          if (e.kind == 3) begin
            chk(out_mag == '0, "R8", "zero vector magnitude", real'(out_mag), 0.0);
          end else begin
            d = real'(out_mag) - e.mag;
            chk(d <= MAG_TOL && d >= -MAG_TOL, tag_of(e.kind, 1'b0), "magnitude",
                real'(out_mag), e.mag);
            d = real'($signed(out_phase)) - e.ph;
            d = d - 65536.0 * $floor((d + 32768.0) / 65536.0);
            chk(d <= PH_TOL && d >= -PH_TOL, tag_of(e.kind, 1'b1), "phase",
                real'($signed(out_phase)), e.ph);
          end
        end
      end else if (out_valid) begin
        chk(1'b0, "R3", "result without matching input", 1.0, 0.0);
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog: actual %0d expected %0d results pending", q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    gain = 1.0;
    for (int i = 0; i < NST; i++) gain = gain * $sqrt(1.0 + 2.0 ** (-2.0 * i));

    // R1: inputs active while in reset must leave nothing behind
    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_x     = 16'sd12000;
    in_y     = 16'sd5000;
    in_phase = '0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid during reset", real'(out_valid), 0.0);
    end
    @(negedge clk);
    rst_n    = 1'b1;
    in_valid = 1'b0;
    for (int i = 0; i < NST + 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid after release", real'(out_valid), 0.0);
    end
    mon_on = 1'b1;

    // axes, zero, full scale and wrap corners, back to back (R3 stream)
    send( 20000,      0,      0, 0);
    send(     0,  20000,      0, 0);
    send(-20000,      0,      0, 1);
    send(     0, -20000,   1000, 0);
    send(     0,      0,    500, 3);
    send(-32768, -32768,      0, 4);
    send( 32767,  32767,      0, 4);
    send(-32768,      0,      0, 4);
    send(-20000,      1,  32000, 2);   // R7 with left-half pre-rotation
    send(-20000,     -1, -32000, 2);   // R7 wrap the other way
    send( 15000,  15000,  30000, 2);
    idle(NST + 3);

    // full-circle sweep, continuous stream
    for (int k = 0; k < 256; k++) begin
      real th;
      th = 2.0 * PI * real'(k) / 256.0;
      send(rnd(20000.0 * $cos(th)), rnd(20000.0 * $sin(th)),
           ((k * 4099) % 65536) - 32768, 0);
    end
    // second sweep with irregular gaps (R3 pattern preservation)
    for (int k = 0; k < 256; k++) begin
      real th;
      th = 2.0 * PI * (real'(k) + 0.37) / 256.0;
      send(rnd(32000.0 * $cos(th)), rnd(32000.0 * $sin(th)),
           ((k * 7919) % 65536) - 32768, 0);
      if (k % 3 == 2) idle(k % 4 + 1);
    end
    idle(NST + 6);
    chk(q.size() == 0, "R3", "results outstanding at end", real'(q.size()), 0.0);
    summary();
    $finish;
  end

endmodule